// File: doc/BRIEF.md
# Replicated Register Bank with Steered Access

The block holds one register that exists in several hardware copies, organised as groups of instances, all answering at one shared bus address. A separate selector register, at its own address, names a target group, a target instance and a write mode. In multicast mode a write to the shared address loads the same value into every copy. In unicast mode a write loads only the copy named by the selector. A read of the shared address always returns the one copy named by the selector, whatever the mode bit holds.

An availability input carries one bit per copy. It stands for fuse and power-gating state. A copy whose bit is low, or a group or instance number beyond the built range, counts as terminated. A read steered there returns zero, and a unicast write steered there is dropped without any error indication. The bus has one master: address, write data, write enable and read enable go in, and registered read data comes out.

Top module: `repl_reg_bank`

## Requirements
- R1: After reset every copy holds zero, the selector holds group 0, instance 0 with multicast on (selector word 0x0001_0000), and the read data output is zero.
- R2: The selector sits at address 0x04. Its word has the instance field in bits [3:0], the group field in bits [11:8] and the multicast bit in bit 16. Writing it loads those fields, and reading it returns them with all other bits zero.
- R3: A write to the shared address 0x10 with the multicast bit set loads the write data into every copy, including copies whose availability bit is low.
- R4: A write to the shared address with the multicast bit clear loads only the copy at index group*4+instance, and every other copy keeps its value.
- R5: A read of the shared address returns the copy named by the selector, whether the multicast bit is set or clear.
- R6: A read of the shared address steered to a copy whose availability bit is low, or to a group or instance of 4 or above, returns zero.
- R7: A unicast write steered to a terminated copy changes no copy.
- R8: A read of any address other than 0x04 and 0x10 returns zero, and a write there changes neither the selector nor any copy.
- R9: The read data output changes only in the cycle after a read enable. It then holds the read result until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write enable |
| bus_re | input | 1 | Read enable |
| bus_rdata | output | 32 | Registered read data, valid the cycle after a read |
| avail_mask | input | 16 | Availability bit per copy, index group*4+instance, high means present |

## Verification
The bench builds the block with its default values: 4 groups of 4 instances of 32-bit data, behind 4-bit selector fields. The selector fields are wider than the built range needs, so group and instance numbers from 4 to 15 can be written, and the out-of-range termination path can be exercised through the bus. The availability mask is driven directly. This lets the bench hide a copy, write to it in both modes, and then reveal it again, so that it can tell whether a dropped or a multicast write reached that copy.

// File: rtl/repl_pkg.sv
package repl_pkg;
    // Selector field widths and bit positions in the selector word
    localparam int SEL_GRP_W  = 4;
    localparam int SEL_INST_W = 4;
    localparam int INST_LSB   = 0;
    localparam int GRP_LSB    = 8;
    localparam int MCAST_BIT  = 16;

    typedef struct packed {
        logic                  mcast;
        logic [SEL_GRP_W-1:0]  grp;
        logic [SEL_INST_W-1:0] inst;
    } sel_t;

    localparam sel_t SEL_RESET = '{mcast: 1'b1, grp: '0, inst: '0};
endpackage

// File: rtl/repl_steer.sv
module repl_steer
    import repl_pkg::*;
#(
    parameter int GROUPS = 4,
    parameter int INSTS  = 4,
    localparam int CELLS = GROUPS * INSTS,
    localparam int IW    = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  sel_t             sel,
    input  logic [CELLS-1:0] avail,
    output logic [IW-1:0]    idx,
    output logic             ok
);
    logic grp_in, inst_in;
    int   idx_full;

    always_comb begin
        grp_in   = int'(sel.grp) < GROUPS;
        inst_in  = int'(sel.inst) < INSTS;
        idx_full = int'(sel.grp) * INSTS + int'(sel.inst);
        idx      = grp_in && inst_in ? IW'(idx_full) : '0;
        ok       = grp_in && inst_in && avail[idx];
    end
endmodule

// File: rtl/repl_store.sv
module repl_store #(
    parameter int CELLS = 16,
    parameter int DW    = 32,
    localparam int IW   = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_all,
    input  logic                wr_one,
    input  logic [IW-1:0]       idx,
    input  logic [DW-1:0]       wdata,
    output logic [CELLS*DW-1:0] cells
);
    for (genvar c = 0; c < CELLS; c++) begin : g_cell
        logic [DW-1:0] cell_d, cell_q;

        always_comb begin
            cell_d = cell_q;
            if (wr_all || (wr_one && idx == IW'(c))) begin
                cell_d = wdata;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                cell_q <= '0;
            end else begin
                cell_q <= cell_d;
            end
        end

        assign cells[c*DW +: DW] = cell_q;
    end
endmodule

// File: rtl/repl_rdmux.sv
module repl_rdmux #(
    parameter int CELLS = 16,
    parameter int DW    = 32,
    localparam int IW   = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic [CELLS*DW-1:0] cells,
    input  logic [IW-1:0]       idx,
    input  logic                ok,
    output logic [DW-1:0]       rd
);
    always_comb begin
        rd = '0;
        if (ok) begin
            rd = cells[idx*DW +: DW];
        end
    end
endmodule

// File: rtl/repl_reg_bank.sv
module repl_reg_bank
    import repl_pkg::*;
#(
    parameter int GROUPS            = 4,
    parameter int INSTS             = 4,
    parameter int DW                = 32,
    parameter int AW                = 8,
    parameter logic [AW-1:0] SEL_ADDR  = 8'h04,
    parameter logic [AW-1:0] DATA_ADDR = 8'h10,
    localparam int CELLS = GROUPS * INSTS,
    localparam int IW    = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic [DW-1:0]    bus_wdata,
    input  logic             bus_we,
    input  logic             bus_re,
    output logic [DW-1:0]    bus_rdata,
    input  logic [CELLS-1:0] avail_mask
);
    typedef struct packed {
        sel_t          sel;
        logic [DW-1:0] rdata;
    } state_t;

    state_t             st_d, st_q;
    logic               hit_sel, hit_data;
    logic               wr_all, wr_one;
    logic [IW-1:0]      tgt_idx;
    logic               tgt_ok;
    logic [CELLS*DW-1:0] cells;
    logic [DW-1:0]      cell_rd;
    logic [DW-1:0]      sel_word;

    repl_steer #(.GROUPS(GROUPS), .INSTS(INSTS)) u_steer (
        .sel   (st_q.sel),
        .avail (avail_mask),
        .idx   (tgt_idx),
        .ok    (tgt_ok)
    );

    repl_store #(.CELLS(CELLS), .DW(DW)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_all (wr_all),
        .wr_one (wr_one),
        .idx    (tgt_idx),
        .wdata  (bus_wdata),
        .cells  (cells)
    );

    repl_rdmux #(.CELLS(CELLS), .DW(DW)) u_rdmux (
        .cells (cells),
        .idx   (tgt_idx),
        .ok    (tgt_ok),
        .rd    (cell_rd)
    );

    always_comb begin
        hit_sel  = bus_addr == SEL_ADDR;
        hit_data = bus_addr == DATA_ADDR;
        wr_all   = bus_we && hit_data && st_q.sel.mcast;
        wr_one   = bus_we && hit_data && !st_q.sel.mcast && tgt_ok;

        sel_word = '0;
        sel_word[INST_LSB +: SEL_INST_W] = st_q.sel.inst;
        sel_word[GRP_LSB +: SEL_GRP_W]   = st_q.sel.grp;
        sel_word[MCAST_BIT]              = st_q.sel.mcast;

        st_d = st_q;
        if (bus_we && hit_sel) begin
            st_d.sel.inst  = bus_wdata[INST_LSB +: SEL_INST_W];
            st_d.sel.grp   = bus_wdata[GRP_LSB +: SEL_GRP_W];
            st_d.sel.mcast = bus_wdata[MCAST_BIT];
        end
        if (bus_re) begin
            if (hit_sel) begin
                st_d.rdata = sel_word;
            end else if (hit_data) begin
                st_d.rdata = cell_rd;
            end else begin
                st_d.rdata = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.sel   <= SEL_RESET;
            st_q.rdata <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bus_rdata = st_q.rdata;
endmodule

// File: rtl/repl_reg_bank_chk.sv
module repl_reg_bank_chk
    import repl_pkg::*;
#(
    parameter int GROUPS            = 4,
    parameter int INSTS             = 4,
    parameter int DW                = 32,
    parameter int AW                = 8,
    parameter logic [AW-1:0] SEL_ADDR  = 8'h04,
    parameter logic [AW-1:0] DATA_ADDR = 8'h10,
    localparam int CELLS = GROUPS * INSTS
) (
    input logic                clk,
    input logic                rst_n,
    input logic [AW-1:0]       bus_addr,
    input logic [DW-1:0]       bus_wdata,
    input logic                bus_we,
    input logic                bus_re,
    input logic [DW-1:0]       bus_rdata,
    input sel_t                sel_q,
    input logic                tgt_ok,
    input logic [CELLS*DW-1:0] cells
);
    logic hit_sel, hit_data;
    assign hit_sel  = bus_addr == SEL_ADDR;
    assign hit_data = bus_addr == DATA_ADDR;

    AST_SEL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && hit_sel |=> sel_q.grp == $past(bus_wdata[GRP_LSB +: SEL_GRP_W])
                          && sel_q.inst == $past(bus_wdata[INST_LSB +: SEL_INST_W])
                          && sel_q.mcast == $past(bus_wdata[MCAST_BIT])); // R2

    AST_MCAST_ALL: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && hit_data && sel_q.mcast |=> cells == {CELLS{$past(bus_wdata)}}); // R3

    AST_TERM_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        bus_re && hit_data && !tgt_ok |=> bus_rdata == '0); // R6

    AST_TERM_WRITE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && hit_data && !sel_q.mcast && !tgt_ok |=> $stable(cells)); // R7

    AST_UNMAPPED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we && !hit_sel && !hit_data |=> $stable(cells) && $stable(sel_q)); // R8

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_re |=> $stable(bus_rdata)); // R9
endmodule

bind repl_reg_bank repl_reg_bank_chk #(
    .GROUPS(GROUPS), .INSTS(INSTS), .DW(DW), .AW(AW),
    .SEL_ADDR(SEL_ADDR), .DATA_ADDR(DATA_ADDR)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_we    (bus_we),
    .bus_re    (bus_re),
    .bus_rdata (bus_rdata),
    .sel_q     (st_q.sel),
    .tgt_ok    (tgt_ok),
    .cells     (cells)
);

// File: tb/repl_reg_bank_test.sv
module repl_reg_bank_test;
    localparam logic [7:0] SA = 8'h04;
    localparam logic [7:0] DA = 8'h10;
    localparam logic [7:0] XA = 8'h20;
    localparam int NV = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic        bus_re = 1'b0;
    logic [31:0] bus_rdata;
    logic [15:0] avail_mask = '1;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    repl_reg_bank uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata), .avail_mask(avail_mask)
    );

    function automatic logic [31:0] selw(input int m, input int g, input int i);
        return (32'(m) << 16) | (32'(g) << 8) | 32'(i);
    endfunction

    // op: 0 = write, 1 = read and compare
    localparam logic        V_OP   [NV] = '{0, 0, 0, 0, 1, 0, 1, 0, 1, 0, 0, 1, 0, 1, 1, 1};
    localparam logic [7:0]  V_ADDR [NV] = '{SA, DA, SA, DA, DA, SA, DA, SA, DA, SA, DA, DA, SA, DA, SA, XA};
    localparam logic [31:0] V_DATA [NV] = '{
        32'h0001_0000,  // mcast on, g0 i0
        32'hA5A5_0001,  // R3 load all copies
        32'h0000_0203,  // unicast g2 i3
        32'h1111_2323,  // R4 write one copy
        32'h1111_2323,  // R4 read it back
        32'h0000_0202,  // neighbour g2 i2
        32'hA5A5_0001,  // R4 neighbour untouched
        32'h0001_0301,  // mcast on, g3 i1
        32'hA5A5_0001,  // R5 read with mcast set
        32'h0000_0000,  // unicast g0 i0
        32'h0000_BEEF,  // unicast write
        32'h0000_BEEF,  // R4 read
        32'h0001_0203,  // mcast on, g2 i3
        32'h1111_2323,  // R5 read ignores mode bit
        32'h0001_0203,  // R2 selector readback
        32'h0000_0000   // R8 unmapped read
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_re = 1'b1;
        @(negedge clk);
        bus_re = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] r;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1", bus_rdata, 32'h0);
        rd(SA, r); check("R1", r, 32'h0001_0000);
        rd(DA, r); check("R1", r, 32'h0);

        for (int k = 0; k < NV; k++) begin
            if (V_OP[k]) begin
                rd(V_ADDR[k], r);
                check($sformatf("R2/R4/R5/R8 vec%0d", k), r, V_DATA[k]);
            end else begin
                wr(V_ADDR[k], V_DATA[k]);
            end
        end

        // R2 unused bits read back as zero
        wr(SA, 32'hFFFF_FFFF);
        rd(SA, r); check("R2", r, 32'h0001_0F0F);

        // R6 hidden copy reads zero; out-of-range group reads zero
        avail_mask[11] = 1'b0;
        wr(SA, selw(0, 2, 3));
        rd(DA, r); check("R6", r, 32'h0);
        wr(SA, selw(0, 5, 0));
        rd(DA, r); check("R6", r, 32'h0);
        wr(SA, selw(0, 1, 7));
        rd(DA, r); check("R6", r, 32'h0);

        // R7 unicast write to hidden copy and to out-of-range is dropped
        wr(SA, selw(0, 2, 3));
        wr(DA, 32'hDEAD_0000);
        wr(SA, selw(0, 4, 0));
        wr(DA, 32'hDEAD_0001);
        avail_mask[11] = 1'b1;
        wr(SA, selw(0, 2, 3));
        rd(DA, r); check("R7", r, 32'h1111_2323);
        wr(SA, selw(0, 0, 0));
        rd(DA, r); check("R7", r, 32'h0000_BEEF);

        // R3 multicast reaches a hidden copy
        avail_mask[5] = 1'b0;
        wr(SA, selw(1, 0, 0));
        wr(DA, 32'h7777_5555);
        avail_mask[5] = 1'b1;
        wr(SA, selw(0, 1, 1));
        rd(DA, r); check("R3", r, 32'h7777_5555);
        wr(SA, selw(0, 3, 3));
        rd(DA, r); check("R3", r, 32'h7777_5555);

        // R8 unmapped write changes nothing
        wr(XA, 32'h0000_0000);
        rd(SA, r); check("R8", r, selw(0, 3, 3));
        rd(DA, r); check("R8", r, 32'h7777_5555);

        // R9 read data holds without a read enable
        wr(DA, 32'h0BAD_F00D);
        repeat (2) @(negedge clk);
        check("R9", bus_rdata, 32'h7777_5555);
        rd(DA, r); check("R9", r, 32'h0BAD_F00D);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule